// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronous Reconfiguration

This block drives four independent pulse-width outputs from one clock. Software programs each channel through a small word-addressed register bus. Each channel has a period divider, a prescaler and a high-time count. The output period is the product of the divider and the prescaler terms. The pulse is high for the first part of each period and low for the rest.

Software can change the settings while a channel is running without any glitch on the output. New values sit in staging registers until software sets a commit flag. The channel then copies them into its working set at the end of the period that is running. The commit flag reads back as set until that copy has happened. A disable is also deferred: the running period finishes first, then the pin parks low. When the disable completes, the prescaler and divider fields are rewritten with fixed values.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0 and every output is low.
- R2: The word at byte address 8*ch holds the divider in bits 15:0 and the high-time count in bits 31:16. The word at 8*ch+4 holds the prescaler in bits 15:0, the commit flag in bit 30 and the enable flag in bit 31. Bits 29:16 of that word read 0. Read data appears on the clock edge after the read strobe.
- R3: A write changes only the addressed channel's register.
- R4: A running channel repeats a period of (divider+1)*(prescaler+1) clocks. The output is high for the first high-time*(prescaler+1) clocks of each period.
- R5: Staged values have no effect on a running channel until a commit. After a commit, the period already running completes with its old length, and the new values apply from the next period.
- R6: The commit flag reads 1 from the write that sets it until the values are taken into the working set, then reads 0 without any further write.
- R7: Clearing the enable flag lets the running period finish. The output then stays low, and the register fields are left unchanged until that period ends.
- R8: When a disable completes, the prescaler field becomes 0 and the divider field becomes 1. The high-time field is kept.
- R9: A high-time count of at least divider+1 keeps the output high for whole periods. A high-time count of 0 keeps it low.
- R10: On an idle channel, a write that sets both enable and commit loads the staged values at once. The output rises on the second clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pwm_o | output | NUM_CH | Registered pulse outputs, one bit per channel |

## Verification
The bench commits new settings in the middle of a period and times the next rising edge. A design that applied the settings at once would shorten or stretch that period. The bench also clears the enable flag just after a rising edge and checks two things: the high phase still lasts its full length, and the fields are not yet rewritten. A design that stopped at once would cut the pulse. A design that parked early would show the reset divider value too soon. The bench drives saturating and zero high-time counts to catch an off-by-one in the compare, which would notch a full-high output or let a zero-width pulse through. It also reads the commit flag back while the commit is pending and after it has completed. A flag that never cleared, or cleared before the commit was taken, shows up in those reads.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  parameter int CNT_W  = 16;
  parameter int REG_W  = 32;
  parameter int EN_POS = 31;
  parameter int UP_POS = 30;
  parameter int HI_LSB = 16;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] pre;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cfg,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             clr_up,
  input  logic             park,
  output pwm_cfg_t         stg,
  output logic             en_flag,
  output logic             up_flag,
  output logic [REG_W-1:0] img_cfg,
  output logic [REG_W-1:0] img_ctl
);
  localparam int GAP_W = REG_W - CNT_W - 2;

  pwm_cfg_t stg_q;
  logic     en_q, up_q;
  logic     unused_wbits;

  assign unused_wbits = ^wdata[UP_POS-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
      en_q  <= 1'b0;
      up_q  <= 1'b0;
    end else begin
      if (clr_up) up_q <= 1'b0;
      if (park) begin
        stg_q.div <= CNT_W'(1);
        stg_q.pre <= '0;
      end
      if (wr_cfg) begin
        stg_q.div <= wdata[CNT_W-1:0];
        stg_q.hi  <= wdata[HI_LSB +: CNT_W];
      end
      if (wr_ctl) begin
        stg_q.pre <= wdata[CNT_W-1:0];
        up_q      <= wdata[UP_POS];
        en_q      <= wdata[EN_POS];
      end
    end
  end

  assign stg     = stg_q;
  assign en_flag = en_q;
  assign up_flag = up_q;
  assign img_cfg = {stg_q.hi, stg_q.div};
  assign img_ctl = {en_q, up_q, {GAP_W{1'b0}}, stg_q.pre};

  // R6
  up_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(up_q) |-> $past(clr_up || wr_ctl));

  // R8
  park_div_chk: assert property (@(posedge clk) disable iff (rst)
    (park && !wr_cfg) |=> (stg_q.div == CNT_W'(1)));

  // R8
  park_pre_chk: assert property (@(posedge clk) disable iff (rst)
    (park && !wr_ctl) |=> (stg_q.pre == '0));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] pre_lim,
  input  logic [CNT_W-1:0] div_lim,
  output logic [CNT_W-1:0] slot,
  output logic             wrap
);
  logic [CNT_W-1:0] pre_cnt, per_cnt;
  logic             pre_end;

  assign pre_end = (pre_cnt == pre_lim);
  assign wrap    = run && pre_end && (per_cnt == div_lim);
  assign slot    = per_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (pre_end) begin
      pre_cnt <= '0;
      per_cnt <= (per_cnt == div_lim) ? '0 : per_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (per_cnt <= div_lim && pre_cnt <= pre_lim));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (per_cnt == '0 && pre_cnt == '0));
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pwm_cfg_t stg,
  input  logic     en_flag,
  input  logic     up_flag,
  input  logic     wrap,
  output logic     running,
  output pwm_cfg_t act,
  output logic     clr_up,
  output logic     park
);
  logic     run_q;
  pwm_cfg_t act_q;
  logic     launch, commit, stop, drop, load;

  assign launch = !run_q && en_flag && up_flag;
  assign drop   = !run_q && !en_flag && up_flag;
  assign commit = run_q && wrap && en_flag && up_flag;
  assign stop   = run_q && wrap && !en_flag;
  assign load   = launch || commit;

  assign clr_up = launch || drop || commit || stop;
  assign park   = stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      act_q <= '0;
    end else begin
      if (load) act_q <= stg;
      if (launch)    run_q <= 1'b1;
      else if (stop) run_q <= 1'b0;
    end
  end

  assign running = run_q;
  assign act     = act_q;

  // R7
  stop_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(wrap && !en_flag));

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wrap) |=> $stable(act_q));

  // R10
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && en_flag && up_flag) |=> (run_q && !up_flag));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0]  ch_idx;
  logic              sel_ctl;
  logic              unused_abits;
  logic [REG_W-1:0]  img_cfg [NUM_CH];
  logic [REG_W-1:0]  img_ctl [NUM_CH];
  logic [REG_W-1:0]  rd_mux;
  logic [NUM_CH-1:0] run_v;
  logic [NUM_CH-1:0] out_q;

  assign ch_idx       = bus_addr[ADDR_W-1:3];
  assign sel_ctl      = bus_addr[2];
  assign unused_abits = ^bus_addr[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic             wr_cfg, wr_ctl, hit;
    logic             en_flag, up_flag, clr_up, park, wrap;
    logic [CNT_W-1:0] slot;
    pwm_cfg_t         stg, act;

    assign hit    = bus_we && (ch_idx == IDX_W'(i));
    assign wr_cfg = hit && !sel_ctl;
    assign wr_ctl = hit && sel_ctl;

    pwm_chan_regs u_regs (
      .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_ctl(wr_ctl),
      .wdata(bus_wdata), .clr_up(clr_up), .park(park), .stg(stg),
      .en_flag(en_flag), .up_flag(up_flag),
      .img_cfg(img_cfg[i]), .img_ctl(img_ctl[i])
    );

    pwm_chan_ctrl u_ctrl (
      .clk(clk), .rst(rst), .stg(stg), .en_flag(en_flag),
      .up_flag(up_flag), .wrap(wrap), .running(run_v[i]), .act(act),
      .clr_up(clr_up), .park(park)
    );

    pwm_timebase u_tb (
      .clk(clk), .rst(rst), .run(run_v[i]), .pre_lim(act.pre),
      .div_lim(act.div), .slot(slot), .wrap(wrap)
    );

    always_ff @(posedge clk) begin
      if (rst) out_q[i] <= 1'b0;
      else     out_q[i] <= run_v[i] && (slot < act.hi);
    end

    // R7
    park_low_chk: assert property (@(posedge clk) disable iff (rst)
      !run_v[i] |=> !out_q[i]);
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_idx == IDX_W'(k)) rd_mux = sel_ctl ? img_ctl[k] : img_cfg[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign pwm_o = out_q;
endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int wcyc = 0;
  logic done = 1'b0;

  int   rises[4], rise_cyc[4], fall_cyc[4], period_last[4], high_last[4];
  logic prev[4];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_bank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  initial begin
    for (int c = 0; c < 4; c++) begin
      rises[c] = 0; rise_cyc[c] = 0; fall_cyc[c] = 0;
      period_last[c] = 0; high_last[c] = 0; prev[c] = 1'b0;
    end
  end

  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (pwm_o[c] && !prev[c]) begin
        period_last[c] = cyc - rise_cyc[c];
        rise_cyc[c]    = cyc;
        rises[c]       = rises[c] + 1;
      end
      if (!pwm_o[c] && prev[c]) begin
        high_last[c] = cyc - rise_cyc[c];
        fall_cyc[c]  = cyc;
      end
      prev[c] = pwm_o[c];
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = 5'(addr); bus_wdata = data; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wcyc = cyc;
    bus_we = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = 5'(addr); bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
    data = bus_rdata;
  endtask

  task automatic rd_chk(input int addr, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(addr, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic wait_rise(input int ch);
    int target = rises[ch] + 1;
    int guard = 0;
    while (rises[ch] < target && guard < 2000) begin
      @(negedge clk); #1;
      guard++;
    end
  endtask

  task automatic hold_chk(input int ch, input logic lvl, input int n, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (pwm_o[ch] !== lvl) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    // R1
    chk(pwm_o == 4'b0, "R1 outputs low", pwm_o, 0);
    rd_chk(0, 32'h0, "R1 cfg word zero");
    rd_chk(4, 32'h0, "R1 ctl word zero");
    rd_chk(28, 32'h0, "R1 ch3 ctl word zero");
  endtask

  task automatic t_map;
    // R2 layout, R3 isolation
    wr(16, 32'h0005_0009);
    rd_chk(16, 32'h0005_0009, "R2 cfg readback");
    wr(12, 32'h0ABC_0003);
    rd_chk(12, 32'h0000_0003, "R2 ctl gap bits read zero");
    rd_chk(24, 32'h0, "R3 ch3 cfg untouched");
    rd_chk(4, 32'h0, "R3 ch0 ctl untouched");
    rd_chk(8, 32'h0, "R3 ch1 cfg untouched");
    chk(pwm_o == 4'b0, "R3 no output without enable", pwm_o, 0);
  endtask

  task automatic t_start;
    int w;
    wr(0, 32'h0003_0009);
    wr(4, 32'hC000_0000);
    w = wcyc;
    wait_rise(0);
    // R10
    chk(rise_cyc[0] == w + 2, "R10 first rise timing", rise_cyc[0], w + 2);
    wait_rise(0);
    // R4
    chk(period_last[0] == 10, "R4 period no prescale", period_last[0], 10);
    chk(high_last[0] == 3, "R4 high no prescale", high_last[0], 3);
    rd_chk(4, 32'h8000_0000, "R6 commit flag cleared after launch");
  endtask

  task automatic t_prescale;
    wr(8, 32'h0002_0004);
    wr(12, 32'hC000_0002);
    wait_rise(1);
    wait_rise(1);
    // R4
    chk(period_last[1] == 15, "R4 period with prescale", period_last[1], 15);
    chk(high_last[1] == 6, "R4 high with prescale", high_last[1], 6);
  endtask

  task automatic t_staged;
    int r0;
    wait_rise(0);
    wr(0, 32'h0007_000B);
    wait_rise(0);
    wait_rise(0);
    // R5
    chk(period_last[0] == 10, "R5 staged period ignored", period_last[0], 10);
    chk(high_last[0] == 3, "R5 staged high ignored", high_last[0], 3);
    r0 = rise_cyc[0];
    wr(4, 32'hC000_0000);
    rd_chk(4, 32'hC000_0000, "R6 commit flag pending");
    wait_rise(0);
    chk(rise_cyc[0] - r0 == 10, "R5 running period completes", rise_cyc[0] - r0, 10);
    wait_rise(0);
    chk(period_last[0] == 12, "R5 new period applied", period_last[0], 12);
    chk(high_last[0] == 7, "R5 new high applied", high_last[0], 7);
    rd_chk(4, 32'h8000_0000, "R6 commit flag self-cleared");
  endtask

  task automatic t_extremes;
    wr(16, 32'h0004_0003);
    wr(20, 32'hC000_0001);
    repeat (4) @(negedge clk);
    // R9
    hold_chk(2, 1'b1, 40, "R9 saturated high-time stays high");
    wr(24, 32'h0000_0003);
    wr(28, 32'hC000_0000);
    hold_chk(3, 1'b0, 40, "R9 zero high-time stays low");
    rd_chk(28, 32'h8000_0000, "R6 commit cleared on zero high-time");
  endtask

  task automatic t_disable;
    int r, n0;
    wait_rise(1);
    r = rise_cyc[1];
    n0 = rises[1];
    wr(12, 32'h0000_0002);
    // R7
    rd_chk(8, 32'h0002_0004, "R7 fields kept until period ends");
    repeat (30) @(negedge clk);
    #1;
    chk(fall_cyc[1] - r == 6, "R7 last high phase completes", fall_cyc[1] - r, 6);
    chk(rises[1] == n0, "R7 no new period after disable", rises[1], n0);
    hold_chk(1, 1'b0, 20, "R7 output parked low");
    // R8
    rd_chk(8, 32'h0002_0001, "R8 divider reset, high kept");
    rd_chk(12, 32'h0000_0000, "R8 prescaler reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_map();
    t_start();
    t_prescale();
    t_staged();
    t_extremes();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule